// File: doc/BRIEF.md
# Two-Channel Digital Audio Subframe Encoder

This block produces a continuous two-channel digital audio line stream (the consumer and professional serial audio interface format) from buffered left and right samples and their validity, user and channel-status bits. It runs on a master clock at 128 times the sample rate. Each bit cell therefore lasts two clock cycles, each subframe 64 cycles and each frame 128 cycles. It builds 32-slot subframes with a preamble and even parity, counts frames around a 192-frame block, and drives a complementary pair of biphase-mark coded outputs.

After reset the block stays idle until the upstream serial port reports that a right-channel sample is in progress. On the first clock edge that sees that indication, frame 0 starts with the left subframe, so channel A of every frame is the left channel. A block-start output marks the first 128 frames of each block, one bit cell ahead of the line. Upstream logic uses it to line up the channel-status and user bits it supplies.

Top module: `aes_tx_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `line_p`, `line_n` and `block_start` are all 0 after that edge.
- R2: After reset is released, and until the first edge at which `right_phase` is 1, the block is idle: `line_p` = 0, `line_n` = 1, `block_start` = 0. That first edge starts frame 0 with its left subframe.
- R3: Once running, `right_phase` has no further effect. Only reset stops or restarts the stream.
- R4: Subframe slot layout: slots 0 to 3 hold the preamble, slots 4 to 27 hold the 24-bit sample LSB first (MSB in slot 27), slot 28 validity, slot 29 user, slot 30 channel status, slot 31 parity. The left inputs are taken at the edge that starts a frame. The right inputs are taken at the edge 64 cycles later.
- R5: The preamble is Z (half-cells 11101000) for the left subframe of frame 0 of each block, X (11100010) for every other left subframe, and Y (11100100) for every right subframe. Each pattern is inverted when the line was high just before the preamble.
- R6: The parity slot makes the number of ones in slots 4 to 31 even.
- R7: Biphase-mark coding: the line toggles at the start of every data cell and again mid-cell for a 1. The half-cell for stream position k appears on `line_p` two edges after the start edge plus k cycles, that is, one cycle after the counter reaches it.
- R8: Outside reset, `line_n` is the complement of `line_p` on every cycle.
- R9: `block_start` is 1 during the start cycle. It rises on the last cycle of frame 191 and falls on the last cycle of frame 127, one bit cell before the line shows frame 0 or frame 128 respectively.
- R10: The frame count runs from 0 to 191 and wraps, so a Z preamble recurs every 192 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 128 × sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| right_phase | input | 1 | High while the serial port captures a right sample; arms the start |
| left_sample | input | 24 | Left audio sample |
| left_v | input | 1 | Left validity bit |
| left_u | input | 1 | Left user bit |
| left_c | input | 1 | Left channel-status bit |
| right_sample | input | 24 | Right audio sample |
| right_v | input | 1 | Right validity bit |
| right_u | input | 1 | Right user bit |
| right_c | input | 1 | Right channel-status bit |
| line_p | output | 1 | Biphase-mark line output, positive |
| line_n | output | 1 | Biphase-mark line output, negative |
| block_start | output | 1 | High for frames 0 to 127, one bit cell early |

## Verification
A wrong half-cell counter or a wrong reference level shows up within one subframe, 64 cycles at most, as a missing cell-boundary toggle or a wrong preamble polarity on `line_p`. A bad payload latch or bad parity corrupts one cell of the next subframe. A frame counter that wraps at the wrong value is invisible until the Z preamble or the `block_start` edges land in the wrong frame. It therefore takes up to a full 192-frame block (24,576 cycles) to show, which is why the stream is compared half-cell by half-cell across two block wraps.

// File: rtl/aes_tx_pkg.sv
// Shared constants, payload type and preamble patterns for the line encoder.
package aes_tx_pkg;

    localparam int AUDIO_W      = 24;   // sample bits carried in slots 4..27
    localparam int SUB_HALVES   = 64;   // half-cells per subframe
    localparam int FRAME_HALVES = 2 * SUB_HALVES;
    localparam int CYC_W        = $clog2(FRAME_HALVES);
    localparam int POS_W        = $clog2(SUB_HALVES);

    typedef enum logic [1:0] {
        PRE_X = 2'd0,
        PRE_Y = 2'd1,
        PRE_Z = 2'd2
    } pre_kind_e;

    typedef struct packed {
        logic               c;
        logic               u;
        logic               v;
        logic [AUDIO_W-1:0] data;
    } sub_payload_t;

    // Half-cell pattern for a preamble, first half-cell in bit 7, low reference.
    function automatic logic [7:0] pre_bits(input pre_kind_e kind);
        case (kind)
            PRE_Z:   return 8'b1110_1000;
            PRE_Y:   return 8'b1110_0100;
            default: return 8'b1110_0010;
        endcase
    endfunction

endpackage

// File: rtl/aes_tx_timer.sv
// Frame timer: half-cell counter within a frame, frame counter within a block,
// start arming after reset and the registered block-start output.
// Assumes one clock per half-cell; right_phase is synchronous to clk.
module aes_tx_timer
    import aes_tx_pkg::*;
#(
    parameter int FRAMES     = 192,
    parameter int BLK_FRAMES = 128,
    localparam int FW        = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             right_phase,
    output logic             run,
    output logic [CYC_W-1:0] cyc,
    output logic [FW-1:0]    frm,
    output logic             ld_left,
    output logic             ld_right,
    output logic             blk
);

    localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(FRAME_HALVES - 1);
    localparam logic [CYC_W-1:0] CYC_LEAD  = CYC_W'(FRAME_HALVES - 2);
    localparam logic [CYC_W-1:0] CYC_RIGHT = CYC_W'(SUB_HALVES - 1);

    logic [FW-1:0] frm_next;
    logic [FW-1:0] lead_frm;

    // Next frame number with wrap at the end of the block.
    always_comb begin
        frm_next = (frm == FW'(FRAMES - 1)) ? '0 : frm + 1'b1;
        lead_frm = (cyc >= CYC_LEAD) ? frm_next : frm;
    end

    // Payload load strobes: left at frame start, right at mid-frame.
    assign ld_left  = (!run && right_phase) || (run && cyc == CYC_LAST);
    assign ld_right = run && (cyc == CYC_RIGHT);

    // Counters, arming and the block-start flag (one bit cell ahead of the line).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cyc <= '0;
            frm <= '0;
            blk <= 1'b0;
        end else if (!run) begin
            if (right_phase) begin
                run <= 1'b1;
                cyc <= '0;
                frm <= '0;
                blk <= 1'b1;
            end
        end else begin
            cyc <= cyc + 1'b1;
            if (cyc == CYC_LAST) begin
                frm <= frm_next;
            end
            blk <= (lead_frm < FW'(BLK_FRAMES));
        end
    end

endmodule

// File: rtl/aes_tx_slot_mux.sv
// Slot selector: for a half-cell position in a subframe, gives either the
// preamble pattern or the payload bit of the current slot, parity included.
// Purely combinational; assumes pos counts 0..63 within the subframe.
module aes_tx_slot_mux
    import aes_tx_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             is_right,
    input  logic             first_frame,
    input  sub_payload_t     pay,
    output logic             is_pre,
    output logic [7:0]       pat,
    output logic             dbit
);

    logic [4:0]  slot;
    logic [4:0]  k;
    logic        par;
    logic [27:0] word;
    pre_kind_e   kind;

    // Slot index, preamble choice and the 28-slot payload word with parity.
    always_comb begin
        slot   = pos[POS_W-1:1];
        k      = slot - 5'd4;
        is_pre = (slot < 5'd4);
        kind   = is_right ? PRE_Y : (first_frame ? PRE_Z : PRE_X);
        pat    = pre_bits(kind);
        par    = ^{pay.c, pay.u, pay.v, pay.data};
        word   = {par, pay.c, pay.u, pay.v, pay.data};
        dbit   = is_pre ? 1'b0 : word[k];
    end

endmodule

// File: rtl/aes_tx_bmc.sv
// Biphase-mark line coder with complementary registered outputs.
// Assumes preamble patterns are given for a low reference level; the level
// just before each preamble is captured and used to invert them.
module aes_tx_bmc
    import aes_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [POS_W-1:0] pos,
    input  logic             is_pre,
    input  logic [7:0]       pat,
    input  logic             dbit,
    output logic             line_p,
    output logic             line_n
);

    logic ref_q;
    logic ref_sel;
    logic nxt;

    // Next line level for the current half-cell.
    always_comb begin
        ref_sel = (pos == '0) ? line_p : ref_q;
        if (is_pre) begin
            nxt = pat[3'd7 - pos[2:0]] ^ ref_sel;
        end else if (!pos[0]) begin
            nxt = ~line_p;
        end else begin
            nxt = line_p ^ dbit;
        end
    end

    // Output pair and preamble reference level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_p <= 1'b0;
            line_n <= 1'b0;
            ref_q  <= 1'b0;
        end else if (!run) begin
            line_p <= 1'b0;
            line_n <= 1'b1;
            ref_q  <= 1'b0;
        end else begin
            line_p <= nxt;
            line_n <= ~nxt;
            if (pos == '0) begin
                ref_q <= line_p;
            end
        end
    end

endmodule

// File: rtl/aes_tx_encoder.sv
// Two-channel subframe encoder top: latches left/right payloads at their
// subframe starts, selects slots and drives the biphase-mark line pair.
// Assumes clk runs at 128 x sample rate and inputs are synchronous to it.
module aes_tx_encoder
    import aes_tx_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK  = 192,
    parameter int BLOCK_HIGH_FRAMES = 128,
    localparam int FW               = $clog2(FRAMES_PER_BLOCK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               right_phase,
    input  logic [AUDIO_W-1:0] left_sample,
    input  logic               left_v,
    input  logic               left_u,
    input  logic               left_c,
    input  logic [AUDIO_W-1:0] right_sample,
    input  logic               right_v,
    input  logic               right_u,
    input  logic               right_c,
    output logic               line_p,
    output logic               line_n,
    output logic               block_start
);

    logic             run;
    logic [CYC_W-1:0] cyc;
    logic [FW-1:0]    frm;
    logic             ld_left;
    logic             ld_right;
    sub_payload_t     lp_q;
    sub_payload_t     rp_q;
    sub_payload_t     cur;
    logic             is_pre;
    logic [7:0]       pat;
    logic             dbit;

    aes_tx_timer #(
        .FRAMES     (FRAMES_PER_BLOCK),
        .BLK_FRAMES (BLOCK_HIGH_FRAMES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .right_phase (right_phase),
        .run         (run),
        .cyc         (cyc),
        .frm         (frm),
        .ld_left     (ld_left),
        .ld_right    (ld_right),
        .blk         (block_start)
    );

    // Payload holding registers, one per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= '0;
            rp_q <= '0;
        end else begin
            if (ld_left) begin
                lp_q <= '{c: left_c, u: left_u, v: left_v, data: left_sample};
            end
            if (ld_right) begin
                rp_q <= '{c: right_c, u: right_u, v: right_v, data: right_sample};
            end
        end
    end

    // Channel select by frame half.
    assign cur = cyc[CYC_W-1] ? rp_q : lp_q;

    aes_tx_slot_mux u_mux (
        .pos         (cyc[POS_W-1:0]),
        .is_right    (cyc[CYC_W-1]),
        .first_frame (frm == '0),
        .pay         (cur),
        .is_pre      (is_pre),
        .pat         (pat),
        .dbit        (dbit)
    );

    aes_tx_bmc u_bmc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pos    (cyc[POS_W-1:0]),
        .is_pre (is_pre),
        .pat    (pat),
        .dbit   (dbit),
        .line_p (line_p),
        .line_n (line_n)
    );

endmodule

// File: rtl/aes_tx_encoder_chk.sv
// Property checker for the line encoder, attached to the top by bind.
module aes_tx_encoder_chk
    import aes_tx_pkg::*;
#(
    parameter int FRAMES     = 192,
    parameter int BLK_FRAMES = 128,
    localparam int FW        = $clog2(FRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txp,
    input logic             txn,
    input logic             blk,
    input logic             run,
    input logic [CYC_W-1:0] cyc,
    input logic [FW-1:0]    frm
);

    logic past_rst_low;

    // Remembers that the previous edge saw reset.
    always_ff @(posedge clk) past_rst_low <= !rst_n;

    a_r1_reset_low: assert property (@(posedge clk)
        past_rst_low |-> (!txp && !txn && !blk));

    a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
        !past_rst_low |-> (txn != txp));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !past_rst_low) |-> (!txp && !blk));

    a_r3_stays_running: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    a_r10_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frm < FW'(FRAMES));

    a_r10_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cyc == CYC_W'(FRAME_HALVES - 1) && frm == FW'(FRAMES - 1)) |=> (frm == '0));

    a_r9_blk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!past_rst_low && $fell(blk)) |-> (cyc == CYC_W'(FRAME_HALVES - 1) && frm == FW'(BLK_FRAMES - 1)));

    a_r9_blk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk) |-> ((cyc == CYC_W'(FRAME_HALVES - 1) && frm == FW'(FRAMES - 1)) ||
                        (cyc == '0 && frm == '0)));

    a_r5_preamble_leads_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cyc[POS_W-1:0] == POS_W'(1)) |-> (txp != $past(txp)));

    a_r7_cell_boundary_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cyc[0] && cyc[POS_W-1:1] >= 5'd4) |-> (txp != $past(txp)));

endmodule

bind aes_tx_encoder aes_tx_encoder_chk #(
    .FRAMES     (FRAMES_PER_BLOCK),
    .BLK_FRAMES (BLOCK_HIGH_FRAMES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .txp   (line_p),
    .txn   (line_n),
    .blk   (block_start),
    .run   (run),
    .cyc   (cyc),
    .frm   (frm)
);

// File: tb/aes_tx_encoder_tb.sv
// Bench: random payloads with directed corner frames, line stream compared
// half-cell by half-cell against a model built from the requirements.
module aes_tx_encoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NF_MAIN    = 400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        right_phase;
    logic [23:0] left_sample, right_sample;
    logic        left_v, left_u, left_c, right_v, right_u, right_c;
    logic        line_p, line_n, block_start;

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] a_l[512];
    logic [2:0]  a_lf[512];   // {c,u,v}
    logic [23:0] a_r[512];
    logic [2:0]  a_rf[512];

    always #(CLK_PERIOD / 2) clk = ~clk;

    aes_tx_encoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .right_phase  (right_phase),
        .left_sample  (left_sample),
        .left_v       (left_v),
        .left_u       (left_u),
        .left_c       (left_c),
        .right_sample (right_sample),
        .right_v      (right_v),
        .right_u      (right_u),
        .right_c      (right_c),
        .line_p       (line_p),
        .line_n       (line_n),
        .block_start  (block_start)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            if (n_fail <= 20) $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    // Subframe word from the layout requirement (R4) with even parity (R6).
    function automatic logic [31:0] sub_word(input logic [23:0] d, input logic [2:0] cuv);
        logic [31:0] w;
        w        = '0;
        w[27:4]  = d;
        w[28]    = cuv[0];
        w[29]    = cuv[1];
        w[30]    = cuv[2];
        w[31]    = ^w[30:4];
        return w;
    endfunction

    task automatic fill_frames();
        for (int i = 0; i < 512; i++) begin
            a_l[i]  = 24'($urandom);
            a_r[i]  = 24'($urandom);
            a_lf[i] = 3'($urandom);
            a_rf[i] = 3'($urandom);
        end
        // directed corner frames: all ones, all zero, MSB only, LSB only
        a_l[0] = 24'hFFFFFF; a_lf[0] = 3'b111; a_r[0] = 24'h000000; a_rf[0] = 3'b000;
        a_l[1] = 24'h800000; a_lf[1] = 3'b001; a_r[1] = 24'h000001; a_rf[1] = 3'b100;
        a_l[2] = 24'h000000; a_lf[2] = 3'b010; a_r[2] = 24'hFFFFFF; a_rf[2] = 3'b111;
    endtask

    task automatic set_left(input int f);
        left_sample = a_l[f];
        {left_c, left_u, left_v} = a_lf[f];
    endtask

    task automatic set_right(input int f);
        right_sample = a_r[f];
        {right_c, right_u, right_v} = a_rf[f];
    endtask

    // Caller leaves right_phase high; the next edge starts frame 0.
    task automatic run_frames(input int nf);
        logic        lvl, rf, exp_b;
        logic [7:0]  pat;
        logic [31:0] w;
        lvl = 1'b0;
        rf  = 1'b0;
        for (int m = 0; m < nf * 128; m++) begin
            @(posedge clk); #1;
            if (m >= 1) begin
                int k, n, sub, pos, slot;
                k    = m - 1;
                n    = k / 128;
                sub  = (k / 64) % 2;
                pos  = k % 64;
                slot = pos / 2;
                if (slot < 4) begin
                    if (pos == 0) rf = lvl;
                    pat = (sub == 1) ? 8'b1110_0100 :
                          ((n % 192) == 0) ? 8'b1110_1000 : 8'b1110_0010;
                    lvl = pat[7 - pos] ^ rf;
                end else if (pos % 2 == 0) begin
                    lvl = ~lvl;
                end else begin
                    w   = (sub == 1) ? sub_word(a_r[n], a_rf[n]) : sub_word(a_l[n], a_lf[n]);
                    lvl = lvl ^ w[slot];
                end
            end
            // R4 R5 R6 R7 R10: line level per half-cell
            check(line_p === ((m >= 1) ? lvl : 1'b0), "R4 R5 R6 R7 R10 line_p",
                  int'(line_p), int'((m >= 1) ? lvl : 1'b0));
            // R8: complementary pair
            check(line_n === ~line_p, "R8 line_n", int'(line_n), int'(~line_p));
            // R9: block start, one bit cell ahead
            exp_b = ((((m + 1) / 128) % 192) < 128);
            check(block_start === exp_b, "R9 block_start", int'(block_start), int'(exp_b));
            // R3: start request toggles freely once running
            right_phase = 1'($urandom);
            if (m % 128 == 32) set_right(m / 128);
            if (m % 128 == 96) set_left(m / 128 + 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; right_phase = 1'b0;
        left_sample = '0; right_sample = '0;
        {left_v, left_u, left_c, right_v, right_u, right_c} = '0;
        fill_frames();

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check(!line_p && !line_n && !block_start, "R1 reset outputs",
                  int'({line_p, line_n, block_start}), 0);
        end
        rst_n = 1'b1;
        // R2: idle until right_phase, data changes ignored
        for (int i = 0; i < 20; i++) begin
            left_sample = 24'($urandom); right_sample = 24'($urandom);
            @(posedge clk); #1;
            check(line_p === 1'b0 && line_n === 1'b1 && block_start === 1'b0, "R2 idle outputs",
                  int'({line_p, line_n, block_start}), 3'b010);
        end
        set_left(0);
        right_phase = 1'b1;
        run_frames(NF_MAIN);

        // R1 again mid-stream, with right_phase held high through reset
        rst_n = 1'b0; right_phase = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check(!line_p && !line_n && !block_start, "R1 mid-stream reset",
                  int'({line_p, line_n, block_start}), 0);
        end
        fill_frames();
        set_left(0);
        rst_n = 1'b1;
        run_frames(6);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule